// File: doc/BRIEF.md
# Cluster Energy Current Reference

This block turns the capacitor voltages of one star-connected phase leg into an active current reference for that phase. Each time a sample strobe arrives, it takes the N cell voltages and forms their mean, the cluster voltage. It squares that mean, which is a measure of the energy stored in the leg, and takes it away from a squared DC set-point. The energy error is scaled by one proportional gain and then multiplied by a cosine sample supplied from outside. That cosine is aligned to the phase (θ, θ−120° or θ+120°), so the resulting current is in phase with the grid voltage.

The datapath is a fixed six-stage pipeline with no stalls, so it accepts a new sample on every clock. Division by N uses a reciprocal constant computed at elaboration. The energy error, the gain product and the cosine product are all kept at full width, and the result is rounded only once, at the end. The output is then clamped to the signed output word. A one-cycle valid pulse follows each strobe through the pipeline. Phase tracking, cosine generation and the current loop are outside this block.

Top module: `cluster_iref`

## Requirements
- R1: While reset is held and after it is released, with no strobe, `iref_vld` is 0 and `iref` is 0.
- R2: The cluster mean is the exact value floor(S·16/N), in unsigned fixed point with 4 fraction bits, where S is the sum of the N unsigned 16-bit cells packed at bit offsets 16·i. With N = 9 and the other inputs held, this term alone decides the output.
- R3: The energy error is `vref_sq`·256 minus the square of the mean, as a signed value. `vref_sq` is an unsigned integer in squared cell-voltage LSBs. When the mean exceeds the set-point, the error is negative.
- R4: The error is multiplied by `k_gain`, which is unsigned with 8 fraction bits, and then by `cos_ph`, which is signed with 14 fraction bits. A gain of 0 or a cosine of 0 gives an output of 0.
- R5: The full product is shifted right by 30 bits with round-half-up: 2^29 is added and then an arithmetic shift is applied. An exact +0.5 becomes 1, and an exact −0.5 becomes 0.
- R6: A result above 32767 is output as 32767, and a result below −32768 is output as −32768. It never wraps.
- R7: `iref_vld` rises six clock edges after the edge that samples `smp_stb`, and there is exactly one pulse per strobe.
- R8: `iref` holds its last value in every cycle where `iref_vld` is low.
- R9: The data inputs are captured only in a cycle where `smp_stb` is high. Changes to them in other cycles have no effect on any result.
- R10: Strobes on consecutive cycles each give their own result, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | Sample strobe; captures all data inputs |
| cell_v | input | N·16 | Cell voltages, unsigned, cell i at bits 16·i+15:16·i |
| vref_sq | input | 32 | Squared DC set-point, unsigned |
| k_gain | input | 16 | Proportional gain, unsigned, 8 fraction bits |
| cos_ph | input | 16 | Phase-aligned cosine, signed, 14 fraction bits |
| iref | output | 16 | Current reference, signed, saturated |
| iref_vld | output | 1 | One-cycle pulse marking a new `iref` |

## Verification
Two things can happen in the same cycle: a new sample is captured, and the result of an earlier sample leaves the pipeline. When strobes come back to back, every stage is busy at once. The bench provokes this with runs of consecutive strobes, some of which carry saturating operands. It judges the results through a queue of expected values, each stamped with the edge count at which it was sent. Any mixing of stages, loss of a result or slip in latency then shows up as a wrong value or a wrong arrival edge. Between strobes the bench drives junk on every data input, so capture outside the strobe cycle is caught as well.

// File: rtl/cluster_iref_pkg.sv
// Shared constants and elaboration-time helpers for the cluster current
// reference pipeline. Assumes shift amounts below 63.
package cluster_iref_pkg;

    // Edges from strobe sample to valid output.
    localparam int LAT = 6;

    // Ceiling of 2^sh / n, used as a fixed-point reciprocal of the cell count.
    function automatic longint recip_const(input int n, input int sh);
        longint num;
        num = longint'(1) <<< sh;
        return (num + longint'(n) - 1) / longint'(n);
    endfunction

endpackage

// File: rtl/ciref_cell_mean.sv
// Two-stage cluster mean: stage 1 sums N unsigned cells, stage 2 multiplies by
// a ceiling reciprocal and shifts, giving floor(sum*2^MF/N) exactly. The
// reciprocal shift is chosen so that the rounding error never reaches 1 LSB.
module ciref_cell_mean #(
    parameter int N  = 9,
    parameter int VW = 16,
    parameter int MF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic [N*VW-1:0]   cells_i,
    output logic              sum_vld_o,
    output logic [VW+MF-1:0]  mean_o,
    output logic              vld_o
);
    import cluster_iref_pkg::*;

    localparam int LGN = (N > 1) ? $clog2(N) : 1;
    localparam int SW  = VW + LGN;
    localparam int RSH = SW + MF + LGN;
    localparam int RW  = RSH + 1;
    localparam int PW  = SW + RW;
    localparam int MW  = VW + MF;
    localparam int SHM = RSH - MF;
    localparam logic [RW-1:0] RECIP   = RW'(recip_const(N, RSH));
    localparam logic [MW-1:0] MEAN_MX = {{VW{1'b1}}, {MF{1'b0}}};

    logic [SW-1:0] sum_c;
    logic [SW-1:0] sum_q;
    logic [PW-1:0] prod_c;
    logic [MW-1:0] mean_c;

    // Adds all cells of the leg.
    always_comb begin
        sum_c = '0;
        for (int i = 0; i < N; i++) begin
            sum_c = sum_c + SW'(cells_i[i*VW +: VW]);
        end
    end

    // Registers the sum on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q     <= '0;
            sum_vld_o <= 1'b0;
        end else begin
            sum_vld_o <= stb_i;
            if (stb_i) sum_q <= sum_c;
        end
    end

    // Reciprocal multiply and shift to the fixed-point mean.
    always_comb begin
        prod_c = PW'(sum_q) * PW'(RECIP);
        mean_c = MW'(prod_c >> SHM);
    end

    // Registers the mean.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mean_o <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= sum_vld_o;
            if (sum_vld_o) mean_o <= mean_c;
        end
    end

    AST_MEAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (mean_o <= MEAN_MX)); // R2

endmodule

// File: rtl/ciref_energy_err.sv
// Energy error stage: squares the fixed-point mean and subtracts it from the
// squared set-point scaled to the same fraction (2*MF bits). One register.
module ciref_energy_err #(
    parameter int VW = 16,
    parameter int MF = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          vld_i,
    input  logic [VW+MF-1:0]              mean_i,
    input  logic [2*VW-1:0]               vref_i,
    output logic signed [2*(VW+MF):0]     err_o,
    output logic                          vld_o
);
    localparam int MW = VW + MF;
    localparam int QW = 2 * MW;

    logic [QW-1:0]      sq_c;
    logic [QW-1:0]      ref_c;
    logic signed [QW:0] err_c;

    // Squares the mean and forms the signed difference.
    always_comb begin
        sq_c  = QW'(mean_i) * QW'(mean_i);
        ref_c = {vref_i, {(2*MF){1'b0}}};
        err_c = $signed({1'b0, ref_c}) - $signed({1'b0, sq_c});
    end

    // Registers the error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) err_o <= err_c;
        end
    end

    AST_ZERO_MEAN_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && mean_i == '0) |=> !err_o[QW]); // R3

endmodule

// File: rtl/ciref_scale.sv
// Two-stage scaling: error times unsigned gain, then times signed cosine. Both
// products are full width; the cosine is carried beside the first product.
module ciref_scale #(
    parameter int EW = 41,
    parameter int KW = 16,
    parameter int CW = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           vld_i,
    input  logic signed [EW-1:0]           err_i,
    input  logic [KW-1:0]                  gain_i,
    input  logic signed [CW-1:0]           cos_i,
    output logic signed [EW+KW+CW:0]       prod_o,
    output logic                           vld_o
);
    localparam int KPW = EW + KW + 1;
    localparam int PPW = KPW + CW;

    logic signed [KPW-1:0] err_x;
    logic signed [KPW-1:0] gain_x;
    logic signed [KPW-1:0] pk_c;
    logic signed [KPW-1:0] pk_q;
    logic signed [CW-1:0]  cos_q;
    logic                  vk_q;
    logic signed [PPW-1:0] pk_x;
    logic signed [PPW-1:0] cos_x;
    logic signed [PPW-1:0] pc_c;

    // Extends operands and forms the gain product.
    always_comb begin
        err_x  = {{(KPW-EW){err_i[EW-1]}}, err_i};
        gain_x = {{(KPW-KW){1'b0}}, gain_i};
        pk_c   = err_x * gain_x;
    end

    // Registers the gain product and delays the cosine beside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pk_q  <= '0;
            cos_q <= '0;
            vk_q  <= 1'b0;
        end else begin
            vk_q <= vld_i;
            if (vld_i) begin
                pk_q  <= pk_c;
                cos_q <= cos_i;
            end
        end
    end

    // Extends operands and forms the cosine product.
    always_comb begin
        pk_x  = {{(PPW-KPW){pk_q[KPW-1]}}, pk_q};
        cos_x = {{(PPW-CW){cos_q[CW-1]}}, cos_q};
        pc_c  = pk_x * cos_x;
    end

    // Registers the final product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_o <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= vk_q;
            if (vk_q) prod_o <= pc_c;
        end
    end

    AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && gain_i == '0) |=> (pk_q == '0)); // R4

endmodule

// File: rtl/ciref_round_sat.sv
// Output stage: adds half an LSB, shifts arithmetically by SH, clamps to the
// signed OW range, registers. Output holds when no valid arrives.
module ciref_round_sat #(
    parameter int IW = 74,
    parameter int SH = 30,
    parameter int OW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  vld_i,
    input  logic signed [IW-1:0]  in_i,
    output logic signed [OW-1:0]  out_o,
    output logic                  vld_o
);
    localparam logic signed [IW:0] RND_C = (IW+1)'(1) << (SH - 1);
    localparam logic signed [IW:0] MAX_W = {{(IW-OW+2){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [IW:0] MIN_W = {{(IW-OW+2){1'b1}}, {(OW-1){1'b0}}};
    localparam logic signed [OW-1:0] MAX_O = {1'b0, {(OW-1){1'b1}}};
    localparam logic signed [OW-1:0] MIN_O = {1'b1, {(OW-1){1'b0}}};

    logic signed [IW:0]   rnd_c;
    logic signed [IW:0]   shf_c;
    logic signed [OW-1:0] sat_c;

    // Rounds half-up, shifts and clamps.
    always_comb begin
        rnd_c = {in_i[IW-1], in_i} + RND_C;
        shf_c = rnd_c >>> SH;
        if (shf_c > MAX_W)      sat_c = MAX_O;
        else if (shf_c < MIN_W) sat_c = MIN_O;
        else                    sat_c = shf_c[OW-1:0];
    end

    // Registers the output word and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_o <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) out_o <= sat_c;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(out_o)); // R8
    AST_NEG_NOT_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && in_i < 0) |=> (out_o <= 0)); // R5

endmodule

// File: rtl/cluster_iref.sv
// Per-phase current reference from cell voltages: mean, squared-energy error,
// gain, phase cosine, round and saturate. Six-stage pipeline, no stalls.
// Side inputs are captured only on the strobe and travel with their sample.
module cluster_iref #(
    parameter int N_CELLS = 9,
    parameter int VW      = 16,
    parameter int MF      = 4,
    parameter int KW      = 16,
    parameter int KF      = 8,
    parameter int CW      = 16,
    parameter int CF      = 14,
    parameter int OW      = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      smp_stb,
    input  logic [N_CELLS*VW-1:0]     cell_v,
    input  logic [2*VW-1:0]           vref_sq,
    input  logic [KW-1:0]             k_gain,
    input  logic signed [CW-1:0]      cos_ph,
    output logic signed [OW-1:0]      iref,
    output logic                      iref_vld
);
    import cluster_iref_pkg::*;

    localparam int MW  = VW + MF;
    localparam int EW  = 2 * MW + 1;
    localparam int PPW = EW + KW + CW + 1;
    localparam int SH  = 2 * MF + KF + CF;

    logic                   v1, v2, v3, v5;
    logic [MW-1:0]          mean_q;
    logic signed [EW-1:0]   err_q;
    logic signed [PPW-1:0]  prod_q;

    logic [2*VW-1:0]        vr1, vr2;
    logic [KW-1:0]          g1, g2, g3;
    logic signed [CW-1:0]   c1, c2, c3;

    // Carries side operands alongside their sample through the early stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vr1 <= '0; g1 <= '0; c1 <= '0;
            vr2 <= '0; g2 <= '0; c2 <= '0;
            g3  <= '0; c3 <= '0;
        end else begin
            if (smp_stb) begin vr1 <= vref_sq; g1 <= k_gain; c1 <= cos_ph; end
            if (v1)      begin vr2 <= vr1;     g2 <= g1;     c2 <= c1;     end
            if (v2)      begin g3  <= g2;      c3 <= c2;                   end
        end
    end

    ciref_cell_mean #(.N(N_CELLS), .VW(VW), .MF(MF)) u_mean (
        .clk(clk), .rst_n(rst_n), .stb_i(smp_stb), .cells_i(cell_v),
        .sum_vld_o(v1), .mean_o(mean_q), .vld_o(v2)
    );

    ciref_energy_err #(.VW(VW), .MF(MF)) u_err (
        .clk(clk), .rst_n(rst_n), .vld_i(v2), .mean_i(mean_q), .vref_i(vr2),
        .err_o(err_q), .vld_o(v3)
    );

    ciref_scale #(.EW(EW), .KW(KW), .CW(CW)) u_scale (
        .clk(clk), .rst_n(rst_n), .vld_i(v3), .err_i(err_q), .gain_i(g3),
        .cos_i(c3), .prod_o(prod_q), .vld_o(v5)
    );

    ciref_round_sat #(.IW(PPW), .SH(SH), .OW(OW)) u_out (
        .clk(clk), .rst_n(rst_n), .vld_i(v5), .in_i(prod_q),
        .out_o(iref), .vld_o(iref_vld)
    );

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        iref_vld == $past(smp_stb, LAT)); // R7
    AST_VALID_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> !iref_vld); // R1

endmodule

// File: tb/cluster_iref_bench.sv
// Scoreboard bench: the driver pushes integer-model results, the monitor pops
// and compares them on the valid pulses, checking value and arrival edge.
module cluster_iref_bench;
    localparam int N   = 9;
    localparam int VW  = 16;
    localparam int LAT = 6;

    typedef struct {
        logic signed [15:0] val;
        int                 stamp;
        string              req;
    } exp_t;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  smp_stb = 1'b0;
    logic [N*VW-1:0]       cell_v = '0;
    logic [31:0]           vref_sq = '0;
    logic [15:0]           k_gain = '0;
    logic signed [15:0]    cos_ph = '0;
    logic signed [15:0]    iref;
    logic                  iref_vld;

    int checks = 0;
    int errors = 0;
    int pcnt = 0;
    exp_t sb[$];
    logic signed [15:0] last_out = '0;
    bit done = 0;

    cluster_iref u_cluster_iref (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .cell_v(cell_v),
        .vref_sq(vref_sq), .k_gain(k_gain), .cos_ph(cos_ph),
        .iref(iref), .iref_vld(iref_vld)
    );

    always #4 clk = ~clk;

    always @(posedge clk) pcnt <= pcnt + 1;

    // Integer reference model of R2..R6.
    function automatic logic signed [15:0] model(input logic [N*VW-1:0] cv,
            input logic [31:0] vr, input logic [15:0] g, input logic signed [15:0] c);
        longint sum, mean, err;
        logic signed [127:0] a, b, p, r;
        sum = 0;
        for (int i = 0; i < N; i++) sum += longint'(cv[i*VW +: VW]);
        mean = (sum * 16) / N;
        err  = longint'(vr) * 256 - mean * mean;
        a = err;
        b = longint'(g) * longint'(c);
        p = a * b;
        r = (p + (128'sd1 <<< 29)) >>> 30;
        if (r > 32767) return 16'sd32767;
        if (r < -32768) return -16'sd32768;
        return r[15:0];
    endfunction

    function automatic logic [N*VW-1:0] fill(input int v);
        logic [N*VW-1:0] f;
        for (int i = 0; i < N; i++) f[i*VW +: VW] = 16'(v);
        return f;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drives one strobe cycle and records the expected result.
    task automatic drive_one(input logic [N*VW-1:0] cv, input logic [31:0] vr,
            input logic [15:0] g, input logic signed [15:0] c, input string req);
        exp_t e;
        @(negedge clk);
        smp_stb = 1'b1; cell_v = cv; vref_sq = vr; k_gain = g; cos_ph = c;
        e.val = model(cv, vr, g, c); e.stamp = pcnt + LAT; e.req = req;
        sb.push_back(e);
    endtask

    // Idle cycles with junk on the data inputs (R9).
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            smp_stb = 1'b0;
            for (int i = 0; i < N; i++) cell_v[i*VW +: VW] = 16'($urandom);
            vref_sq = $urandom; k_gain = 16'($urandom); cos_ph = 16'($urandom);
        end
    endtask

    // Monitor: pops on valid, checks hold otherwise.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (iref_vld) begin
                if (sb.size() == 0) begin
                    check(0, "R7 unexpected valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(iref == e.val, e.req, iref, e.val);
                    check(pcnt == e.stamp, "R7 arrival edge", pcnt, e.stamp);
                end
                last_out = iref;
            end else begin
                check(iref == last_out, "R8 hold", iref, last_out);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (pcnt == 60000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", pcnt, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N*VW-1:0] cv;
        repeat (4) @(negedge clk);
        check(iref_vld == 1'b0 && iref == 16'sd0, "R1 in reset", iref, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(iref_vld == 1'b0 && iref == 16'sd0, "R1 after reset", iref, 0);

        // R2: exact mean, 1..9 -> 5.0 and a non-divisible sum
        cv = '0;
        for (int i = 0; i < N; i++) cv[i*VW +: VW] = 16'(i + 1);
        drive_one(cv, 32'd30, 16'd256, 16'sd16384, "R2 mean 5.0");
        idle(2);
        cv = '0; cv[3*VW +: VW] = 16'd10;
        drive_one(cv, 32'd1, 16'd256, 16'sd16384, "R2 floor mean");
        idle(1);
        // R3: mean above set-point gives negative
        drive_one(fill(40), 32'd100, 16'd256, 16'sd16384, "R3 negative error");
        idle(1);
        // R4: zero gain, zero cosine, negative cosine
        drive_one(fill(100), 32'd1000, 16'd0, 16'sd16384, "R4 zero gain");
        drive_one(fill(100), 32'd20000, 16'd300, 16'sd0, "R4 zero cosine");
        drive_one(fill(10), 32'd500, 16'd128, -16'sd11585, "R4 phase cosine");
        idle(1);
        // R5: half-up rounding at +0.5 and -0.5
        drive_one(fill(0), 32'd1, 16'd256, 16'sd8192, "R5 plus half");
        drive_one(fill(0), 32'd1, 16'd256, -16'sd8192, "R5 minus half");
        idle(1);
        // R6: saturation both ways, back to back (R10)
        drive_one(fill(0), 32'd40000, 16'd256, 16'sd16384, "R6 high clamp");
        drive_one(fill(60000), 32'd0, 16'd256, 16'sd16384, "R6 low clamp");
        drive_one(fill(0), 32'd32767, 16'd256, 16'sd16384, "R6 edge 32767");
        drive_one(fill(0), 32'd40000, 16'd256, -16'sd16384, "R10 back to back");
        drive_one(fill(7), 32'd49, 16'd256, 16'sd16384, "R10 back to back");
        idle(3);
        // Random patterns with junk gaps (R9, R10)
        for (int n = 0; n < 60; n++) begin
            int base;
            base = 3000 + int'($urandom % 200);
            cv = '0;
            for (int i = 0; i < N; i++) cv[i*VW +: VW] = 16'(base + int'($urandom % 64));
            drive_one(cv, 32'((3100 + $urandom % 64) * (3100 + $urandom % 64)),
                      16'($urandom % 512), 16'(int'($urandom % 32769) - 16384),
                      "R9 random sample");
            idle(int'($urandom % 3));
        end
        idle(LAT + 4);
        check(sb.size() == 0, "R7 all results seen", sb.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule